// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard control logic for an in-order processor pipeline with five stages: fetch, register read, ALU, memory and write-back. It watches the source register numbers of the instruction now in register read and the destination, write-enable and load flags of the instructions in the three stages after it. From these it decides each cycle whether the front of the pipeline must hold and whether a no-op goes into the ALU stage. It also sets the ALU operand bypass selects for the instruction that enters the ALU stage next.

Two operating modes are chosen by an input bit. With bypassing off, a dependent instruction waits in register read until its producer has left write-back. With bypassing on, only a load followed by a user of its result costs a bubble. Every other dependence is served from a bypass path.

Branches are fetched as not taken. A branch resolves in the memory stage, and a taken branch redirects the PC and squashes the three younger instructions. When instruction fetch and data access share one memory port, a load or store in the memory stage takes the port and fetch inserts a bubble for that cycle. The datapath, register file, memories and predictor live outside the block.

Top module: `pipe_hazard_unit`

## Requirements
- R1: In the first cycle after reset with all inputs idle, every control output and both bypass selects are 0.
- R2: With `fwd_en`=0, if a nonzero source of the register-read instruction equals the destination of a writing instruction in the ALU, memory or write-back stage, then `pc_hold`, `rr_hold` and `ex_bubble` are 1 in that cycle. A consumer right behind its producer therefore waits 3 cycles, and one with a single independent instruction in between waits 2 cycles.
- R3: With `fwd_en`=1, a data stall happens only when the ALU-stage instruction is a writing load whose destination matches a nonzero source. A load followed by its user costs exactly one bubble cycle, and non-load producers never stall.
- R4: With `fwd_en`=1, the bypass select of each operand is registered and appears in the cycle after the register-read instruction moves into the ALU stage. The encoding is 0 = register file, 1 = result now in memory stage, 2 = result now in write-back, 3 = value written back one cycle earlier. When more than one stage matches, the youngest producer wins.
- R5: Register 0 never matches: a source or destination of 0 causes no stall and no bypass.
- R6: After a cycle with a data stall or a taken branch, and whenever `fwd_en`=0, both bypass selects are 0.
- R7: With `shared_mem`=1 and `mem_access`=1, `pc_hold` and `fetch_bubble` are 1 and `rr_hold` and `ex_bubble` are 0, unless there is also a data stall. With `shared_mem`=0, `mem_access` has no effect on any output.
- R8: When `br_resolved` and `br_taken` are both 1, `pc_redirect` is 1 and `squash` is 3'b111 (bit 0 fetch, bit 1 register read, bit 2 ALU stage). All holds and bubbles are 0 in that cycle, even if a data stall or port conflict is also present.
- R9: A branch that resolves not taken changes no output compared with the same cycle without the branch.
- R10: When a data stall and a port conflict occur together, `rr_hold` is 1 and `fetch_bubble` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = bypass mode, 0 = stall-until-retire mode |
| shared_mem | input | 1 | 1 = fetch and data share one memory port |
| rr_rs1 | input | REG_W | First source register of the register-read instruction (0 = unused) |
| rr_rs2 | input | REG_W | Second source register of the register-read instruction (0 = unused) |
| ex_rd | input | REG_W | Destination of the ALU-stage instruction |
| ex_we | input | 1 | ALU-stage instruction writes a register |
| ex_load | input | 1 | ALU-stage instruction is a load |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_access | input | 1 | Memory-stage instruction is a load or store |
| wb_rd | input | REG_W | Destination of the write-back instruction |
| wb_we | input | 1 | Write-back instruction writes a register |
| br_resolved | input | 1 | A branch in the memory stage resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| pc_hold | output | 1 | Keep the PC unchanged |
| pc_redirect | output | 1 | Load the branch target into the PC |
| rr_hold | output | 1 | Keep the fetch/register-read pipeline register |
| fetch_bubble | output | 1 | Load a no-op into the fetch/register-read register |
| ex_bubble | output | 1 | Load a no-op (write enable clear) into the ALU stage |
| squash | output | 3 | Younger instructions to discard |
| fwd_a | output | 2 | Bypass select, first ALU operand |
| fwd_b | output | 2 | Bypass select, second ALU operand |

## Verification
The assertions check on every cycle that a taken branch wins over every hold and bubble, and that a hold always comes with a matching ALU bubble and no fetch bubble. They also check that a load-use match in bypass mode always stalls, and that the bypass selects go to 0 after a bubble, with register 0 as a source, or in stall mode. The stall lengths that come out of a producer moving through the stages (three, two or one cycle), the youngest-producer priority among the four select codes, and the fact that an unshared port or a not-taken branch changes nothing can only be seen from the bench's scenarios and its cycle-by-cycle reference model.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2,
    FWD_OLD = 2'd3
  } fwd_sel_e;

  localparam int NUM_OPND  = 2;
  localparam int NUM_YOUNG = 3;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             fwd_en,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic             stall_req,
  output fwd_sel_e         sel_nxt
);
  logic src_live;
  logic hit_ex, hit_mem, hit_wb;

  assign src_live = (src != '0);
  assign hit_ex   = src_live && ex_we  && (ex_rd  == src);
  assign hit_mem  = src_live && mem_we && (mem_rd == src);
  assign hit_wb   = src_live && wb_we  && (wb_rd  == src);

  always_comb begin
    stall_req = 1'b0;
    sel_nxt   = FWD_RF;
    if (!fwd_en) begin
      stall_req = hit_ex || hit_mem || hit_wb;
    end else begin
      stall_req = hit_ex && ex_load;
      if (hit_ex)       sel_nxt = FWD_MEM;
      else if (hit_mem) sel_nxt = FWD_WB;
      else if (hit_wb)  sel_nxt = FWD_OLD;
    end
  end
endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  fwd_sel_e nxt,
  output fwd_sel_e q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= FWD_RF;
    else            q <= nxt;
  end
endmodule

// File: rtl/hz_ctrl_core.sv
module hz_ctrl_core
  import hz_pkg::*;
(
  input  logic                 data_stall,
  input  logic                 shared_mem,
  input  logic                 mem_access,
  input  logic                 br_resolved,
  input  logic                 br_taken,
  output logic                 pc_hold,
  output logic                 pc_redirect,
  output logic                 rr_hold,
  output logic                 fetch_bubble,
  output logic                 ex_bubble,
  output logic [NUM_YOUNG-1:0] squash,
  output logic                 fwd_clr
);
  logic flush, conflict;

  assign flush    = br_resolved && br_taken;
  assign conflict = shared_mem && mem_access;
  assign fwd_clr  = flush || data_stall;

  always_comb begin
    pc_hold      = 1'b0;
    pc_redirect  = 1'b0;
    rr_hold      = 1'b0;
    fetch_bubble = 1'b0;
    ex_bubble    = 1'b0;
    squash       = '0;
    if (flush) begin
      pc_redirect = 1'b1;
      squash      = '1;
    end else begin
      pc_hold      = data_stall || conflict;
      rr_hold      = data_stall;
      ex_bubble    = data_stall;
      fetch_bubble = conflict && !data_stall;
    end
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_en,
  input  logic             shared_mem,
  input  logic [REG_W-1:0] rr_rs1,
  input  logic [REG_W-1:0] rr_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic             mem_access,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  input  logic             br_resolved,
  input  logic             br_taken,
  output logic             pc_hold,
  output logic             pc_redirect,
  output logic             rr_hold,
  output logic             fetch_bubble,
  output logic             ex_bubble,
  output logic [2:0]       squash,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b
);
  logic [REG_W-1:0]    src_arr [NUM_OPND];
  logic [NUM_OPND-1:0] stall_vec;
  fwd_sel_e            sel_nxt [NUM_OPND];
  fwd_sel_e            sel_q   [NUM_OPND];
  logic                fwd_clr;

  assign src_arr[0] = rr_rs1;
  assign src_arr[1] = rr_rs2;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_src_match #(.REG_W(REG_W)) u_match (
      .fwd_en    (fwd_en),
      .src       (src_arr[g]),
      .ex_rd     (ex_rd),
      .ex_we     (ex_we),
      .ex_load   (ex_load),
      .mem_rd    (mem_rd),
      .mem_we    (mem_we),
      .wb_rd     (wb_rd),
      .wb_we     (wb_we),
      .stall_req (stall_vec[g]),
      .sel_nxt   (sel_nxt[g])
    );

    hz_fwd_reg u_sel (
      .clk (clk),
      .rst (rst),
      .clr (fwd_clr),
      .nxt (sel_nxt[g]),
      .q   (sel_q[g])
    );
  end

  hz_ctrl_core u_core (
    .data_stall   (|stall_vec),
    .shared_mem   (shared_mem),
    .mem_access   (mem_access),
    .br_resolved  (br_resolved),
    .br_taken     (br_taken),
    .pc_hold      (pc_hold),
    .pc_redirect  (pc_redirect),
    .rr_hold      (rr_hold),
    .fetch_bubble (fetch_bubble),
    .ex_bubble    (ex_bubble),
    .squash       (squash),
    .fwd_clr      (fwd_clr)
  );

  assign fwd_a = sel_q[0];
  assign fwd_b = sel_q[1];
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             fwd_en,
  input logic [REG_W-1:0] rr_rs1,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_we,
  input logic             ex_load,
  input logic             br_resolved,
  input logic             br_taken,
  input logic             pc_hold,
  input logic             pc_redirect,
  input logic             rr_hold,
  input logic             fetch_bubble,
  input logic             ex_bubble,
  input logic [2:0]       squash,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b
);
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    pc_redirect |-> (squash == 3'b111) && !pc_hold && !rr_hold && !ex_bubble && !fetch_bubble); // R8

  AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !br_taken |-> !pc_redirect && (squash == 3'b000)); // R9

  AST_HOLD_SET: assert property (@(posedge clk) disable iff (rst)
    rr_hold |-> pc_hold && ex_bubble && !fetch_bubble); // R10

  AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && ex_we && ex_load && (ex_rd != '0) && (rr_rs1 == ex_rd) && !(br_resolved && br_taken))
      |-> ex_bubble); // R3

  AST_BUBBLE_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ex_bubble || pc_redirect) |=> (fwd_a == 2'd0) && (fwd_b == 2'd0)); // R6

  AST_NOFWD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    !fwd_en |=> (fwd_a == 2'd0) && (fwd_b == 2'd0)); // R6

  AST_REG0_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (rr_rs1 == '0) |=> (fwd_a == 2'd0)); // R5
endmodule

bind pipe_hazard_unit hz_checker #(.REG_W(REG_W)) u_hz_chk (
  .clk          (clk),
  .rst          (rst),
  .fwd_en       (fwd_en),
  .rr_rs1       (rr_rs1),
  .ex_rd        (ex_rd),
  .ex_we        (ex_we),
  .ex_load      (ex_load),
  .br_resolved  (br_resolved),
  .br_taken     (br_taken),
  .pc_hold      (pc_hold),
  .pc_redirect  (pc_redirect),
  .rr_hold      (rr_hold),
  .fetch_bubble (fetch_bubble),
  .ex_bubble    (ex_bubble),
  .squash       (squash),
  .fwd_a        (fwd_a),
  .fwd_b        (fwd_b)
);

// File: tb/tb_pipe_hazard_unit.sv
`timescale 1ns/1ps
module tb_pipe_hazard_unit;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, fwd_en, shared_mem, mem_access, br_resolved, br_taken;
  logic ex_we, ex_load, mem_we, wb_we;
  logic [RW-1:0] rr_rs1, rr_rs2, ex_rd, mem_rd, wb_rd;
  logic pc_hold, pc_redirect, rr_hold, fetch_bubble, ex_bubble;
  logic [2:0] squash;
  logic [1:0] fwd_a, fwd_b;

  int checks = 0, errors = 0;
  int exp_fa = 0, exp_fb = 0, nxt_fa = 0, nxt_fb = 0;
  int e_hold, e_redir, e_rrh, e_fbub, e_exb, e_sq;
  int last_bub, nb;
  string cur_tag = "R1";

  pipe_hazard_unit #(.REG_W(RW)) dut (
    .clk(clk), .rst(rst), .fwd_en(fwd_en), .shared_mem(shared_mem),
    .rr_rs1(rr_rs1), .rr_rs2(rr_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_access(mem_access), .wb_rd(wb_rd), .wb_we(wb_we),
    .br_resolved(br_resolved), .br_taken(br_taken), .pc_hold(pc_hold), .pc_redirect(pc_redirect),
    .rr_hold(rr_hold), .fetch_bubble(fetch_bubble), .ex_bubble(ex_bubble), .squash(squash),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    finish_up();
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  // Behavioural model: producers listed by distance from register read.
  function automatic void model();
    int rd[3]; bit we[3]; int srcs[2]; int sel[2];
    bit stall = 0, flush, conf;
    rd[0] = ex_rd; rd[1] = mem_rd; rd[2] = wb_rd;
    we[0] = ex_we; we[1] = mem_we; we[2] = wb_we;
    srcs[0] = rr_rs1; srcs[1] = rr_rs2;
    for (int o = 0; o < 2; o++) begin
      sel[o] = 0;
      for (int d = 2; d >= 0; d--) begin
        if (we[d] && rd[d] != 0 && rd[d] == srcs[o]) begin
          sel[o] = d + 1;
          if (!fwd_en || (d == 0 && ex_load)) stall = 1;
        end
      end
      if (!fwd_en) sel[o] = 0;
    end
    flush = br_resolved && br_taken;
    conf  = shared_mem && mem_access;
    e_hold = 0; e_redir = 0; e_rrh = 0; e_fbub = 0; e_exb = 0; e_sq = 0;
    if (flush) begin
      e_redir = 1; e_sq = 7;
    end else begin
      e_hold = stall || conf;
      e_rrh  = stall;
      e_exb  = stall;
      e_fbub = conf && !stall;
    end
    if (rst || flush || stall) begin nxt_fa = 0; nxt_fb = 0; end
    else begin nxt_fa = sel[0]; nxt_fb = sel[1]; end
  endfunction

  task automatic step();
    @(negedge clk);
    model();
    chk("pc_hold", pc_hold, e_hold);
    chk("pc_redirect", pc_redirect, e_redir);
    chk("rr_hold", rr_hold, e_rrh);
    chk("fetch_bubble", fetch_bubble, e_fbub);
    chk("ex_bubble", ex_bubble, e_exb);
    chk("squash", squash, e_sq);
    chk("fwd_a", fwd_a, exp_fa);
    chk("fwd_b", fwd_b, exp_fb);
    last_bub = ex_bubble;
    exp_fa = nxt_fa; exp_fb = nxt_fb;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    rr_rs1 = 0; rr_rs2 = 0; ex_rd = 0; ex_we = 0; ex_load = 0;
    mem_rd = 0; mem_we = 0; mem_access = 0; wb_rd = 0; wb_we = 0;
    br_resolved = 0; br_taken = 0;
  endtask

  initial begin
    rst = 1; fwd_en = 0; shared_mem = 0; idle();
    step(); step();
    rst = 0;

    // R1: reset state
    cur_tag = "R1";
    step();
    chk("reset pc_hold", pc_hold, 0);
    chk("reset ex_bubble", ex_bubble, 0);
    chk("reset fwd_a", fwd_a, 0);
    chk("reset fwd_b", fwd_b, 0);

    // R2: stall mode, producer directly ahead -> 3 cycles
    cur_tag = "R2"; fwd_en = 0; nb = 0; rr_rs1 = 3;
    ex_rd = 3; ex_we = 1; step(); nb += last_bub;
    ex_we = 0; mem_rd = 3; mem_we = 1; step(); nb += last_bub;
    mem_we = 0; wb_rd = 3; wb_we = 1; step(); nb += last_bub;
    wb_we = 0; step(); nb += last_bub;
    chk("back-to-back stall cycles", nb, 3);

    // R2: one independent instruction in between -> 2 cycles
    idle(); nb = 0; rr_rs2 = 8;
    mem_rd = 8; mem_we = 1; step(); nb += last_bub;
    mem_we = 0; wb_rd = 8; wb_we = 1; step(); nb += last_bub;
    wb_we = 0; step(); nb += last_bub;
    chk("gap-of-one stall cycles", nb, 2);

    // R3/R4: bypass mode, ALU producer does not stall
    cur_tag = "R3"; idle(); fwd_en = 1;
    rr_rs1 = 7; ex_rd = 7; ex_we = 1; step();
    chk("alu producer no stall", last_bub, 0);
    cur_tag = "R4";
    chk("ex producer select", fwd_a, 1);

    // R3/R6: load-use costs one bubble, then bypass from write-back
    cur_tag = "R3"; idle(); nb = 0; rr_rs2 = 4;
    ex_rd = 4; ex_we = 1; ex_load = 1; step(); nb += last_bub;
    cur_tag = "R6";
    chk("select after stall", fwd_b, 0);
    cur_tag = "R3";
    ex_we = 0; ex_load = 0; mem_rd = 4; mem_we = 1; step(); nb += last_bub;
    chk("load-use bubble count", nb, 1);
    cur_tag = "R4";
    chk("load value via write-back", fwd_b, 2);

    // R4: youngest producer priority
    idle(); rr_rs1 = 5; ex_rd = 5; ex_we = 1; mem_rd = 5; mem_we = 1; step();
    chk("ex beats mem", fwd_a, 1);
    idle(); rr_rs2 = 6; mem_rd = 6; mem_we = 1; wb_rd = 6; wb_we = 1; step();
    chk("mem beats wb", fwd_b, 2);
    idle(); rr_rs1 = 9; wb_rd = 9; wb_we = 1; step();
    chk("wb only", fwd_a, 3);

    // R5: register 0 never matches
    cur_tag = "R5"; idle(); fwd_en = 0; ex_rd = 0; ex_we = 1; mem_we = 1; step();
    chk("r0 no stall", last_bub, 0);
    fwd_en = 1; ex_load = 1; step();
    chk("r0 no load stall", last_bub, 0);
    chk("r0 no bypass", fwd_a, 0);

    // R7: shared port conflict, and no effect when split
    cur_tag = "R7"; idle(); shared_mem = 1; mem_access = 1; step();
    chk("conflict fetch_bubble", fetch_bubble, 1);
    chk("conflict rr_hold", rr_hold, 0);
    shared_mem = 0; step();
    chk("split port pc_hold", pc_hold, 0);
    chk("split port fetch_bubble", fetch_bubble, 0);

    // R10: data stall together with conflict
    cur_tag = "R10"; shared_mem = 1; fwd_en = 0; rr_rs1 = 2; ex_rd = 2; ex_we = 1; step();
    chk("both rr_hold", rr_hold, 1);
    chk("both fetch_bubble", fetch_bubble, 0);

    // R8: taken branch beats stall and conflict
    cur_tag = "R8"; br_resolved = 1; br_taken = 1; step();
    chk("flush squash", squash, 7);
    chk("flush no bubble", ex_bubble, 0);
    idle(); shared_mem = 0; step();
    chk("select after flush", fwd_a, 0);

    // R9: not-taken branch changes nothing
    cur_tag = "R9"; idle(); fwd_en = 1; br_resolved = 1; rr_rs1 = 11; ex_rd = 11; ex_we = 1; step();
    chk("not taken redirect", pc_redirect, 0);
    chk("not taken bubble", ex_bubble, 0);
    step();
    chk("not taken bypass kept", fwd_a, 1);

    // Mixed random traffic: R2 R3 R4 R5 R6 R7 R8 R9 R10
    cur_tag = "R4 random";
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        fwd_en = $urandom_range(0, 1);
        shared_mem = $urandom_range(0, 1);
      end
      rr_rs1 = RW'($urandom_range(0, 3)); rr_rs2 = RW'($urandom_range(0, 3));
      ex_rd = RW'($urandom_range(0, 3)); ex_we = $urandom_range(0, 1);
      ex_load = ex_we && ($urandom_range(0, 2) == 0);
      mem_rd = RW'($urandom_range(0, 3)); mem_we = $urandom_range(0, 1);
      mem_access = $urandom_range(0, 1);
      wb_rd = RW'($urandom_range(0, 3)); wb_we = $urandom_range(0, 1);
      br_resolved = ($urandom_range(0, 3) == 0);
      br_taken = br_resolved && $urandom_range(0, 1);
      step();
    end

    finish_up();
  end
endmodule